// File: doc/BRIEF.md
# Paged Effective Address Generator

This block turns a 12-bit memory-reference instruction word into the final operand address. The instruction carries a 7-bit offset, a page-select flag and an indirect flag. The page-select flag chooses one of two bases for the address. A clear flag selects page zero, so the upper address bits are zero. A set flag selects the current page, so the upper five bits come from the address the instruction was fetched from. The result is called the page address.

When the indirect flag is clear, the page address is the result, and it is ready one cycle after `start`. When the indirect flag is set, the block reads the word stored at the page address over a simple request/ready memory port, and that word becomes the result. Eight fixed pointer cells in page zero auto-increment. An indirect reference through one of them reads the word, adds one, writes the sum back to the same cell, and returns the sum. The result is held on `ea` and announced by a single-cycle `done` pulse.

Top module: `paged_ea_gen`

## Requirements
- R1: Instruction fields sit at `instr[8]` (indirect flag), `instr[7]` (page-select flag) and `instr[6:0]` (offset). The three opcode bits `instr[11:9]` have no effect on any output.
- R2: With the page-select flag clear, the page address is `{5'b0, instr[6:0]}`, which covers octal 0000 to 0177.
- R3: With the page-select flag set, the page address is `{fetch_addr[11:7], instr[6:0]}`.
- R4: A direct reference (indirect flag clear) raises `done` on the first cycle after `start` is accepted, with `ea` equal to the page address. It makes no memory request.
- R5: An indirect reference outside octal 0010 to 0017 issues exactly one read (`mem_we`=0) at the page address. `ea` then takes the word returned on `mem_rdata`, and no write is issued.
- R6: An indirect reference whose page address is in octal 0010 to 0017 reads the pointer and then writes the pointer plus one to that same address. It returns the incremented value on `ea`. Writes only ever target that range.
- R7: The increment wraps modulo 4096, so octal 7777 becomes 0000.
- R8: A direct reference to octal 0010 to 0017 issues no write and leaves the stored pointer unchanged.
- R9: Every memory access keeps `mem_req`, `mem_addr` and `mem_we` steady until a cycle with `mem_ready` high completes it. Completion time therefore stretches with memory latency: 1 + (L+1) cycles for a plain indirect reference, and 1 + 2(L+1) cycles for an auto-increment, where L is the number of wait cycles per access.
- R10: `done` is high for exactly one cycle. `ea` changes only in a cycle where `done` is high, and otherwise holds its last value.
- R11: `start` is accepted only while the block is idle. A `start` during an operation in progress is ignored.
- R12: After reset, `done`, `mem_req` and `mem_we` are low and `ea` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address generation for `instr` |
| instr | input | 12 | Memory-reference instruction word |
| fetch_addr | input | 12 | Address the instruction was fetched from |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 12 | Access address |
| mem_wdata | output | 12 | Write data |
| mem_rdata | input | 12 | Read data, valid when `mem_ready` is high |
| mem_ready | input | 1 | Access completes this cycle |
| ea | output | 12 | Effective address |
| done | output | 1 | One-cycle completion strobe |

## Verification
The hardest case to reach from the ports is the auto-increment write-back. It needs an indirect reference to one of the eight pointer cells, a memory that answers twice, and a stored pointer at 7777 so the wrap can be observed. The bench holds those eight cells in a small writable model and fills every other address with a computed pattern. It walks all eight cells, seeds one of them with 7777, and repeats the walk with several ready latencies. Its cycle count then distinguishes the one-access path from the two-access path. A second `start` is injected in the middle of a slow indirect reference to show that it is dropped.

// File: rtl/pea_pkg.sv
package pea_pkg;
   typedef enum logic [1:0] {
      PEA_IDLE  = 2'd0,
      PEA_READ  = 2'd1,
      PEA_WRITE = 2'd2,
      PEA_DONE  = 2'd3
   } pea_state_t;
endpackage

// File: rtl/pea_decode.sv
module pea_decode #(
   parameter int WORD_W   = 12,
   parameter int OFFS_W   = 7,
   parameter int IND_BIT  = 8,
   parameter int PAGE_BIT = 7
) (
   input  logic [WORD_W-1:0] instr,
   input  logic [WORD_W-1:0] fetch_addr,
   output logic              indirect,
   output logic [WORD_W-1:0] page_addr
);
   localparam int HI_W = WORD_W - OFFS_W;

   logic [OFFS_W-1:0] offset;
   logic [HI_W-1:0]   hi_part;
   logic              page_sel;
   logic              unused_bits;

   assign offset   = instr[OFFS_W-1:0];
   assign page_sel = instr[PAGE_BIT];
   assign indirect = instr[IND_BIT];

   generate
      if (HI_W > 0) begin : g_paged
         assign hi_part = page_sel ? fetch_addr[WORD_W-1:OFFS_W] : '0;
      end else begin : g_flat
         assign hi_part = '0;
      end
   endgenerate

   assign page_addr   = {hi_part, offset};
   assign unused_bits = ^{instr, fetch_addr};
endmodule

// File: rtl/pea_autoinc.sv
module pea_autoinc #(
   parameter int WORD_W     = 12,
   parameter bit AUTO_EN    = 1'b1,
   parameter int AUTO_BASE  = 8,
   parameter int AUTO_COUNT = 8
) (
   input  logic [WORD_W-1:0] ptr_addr,
   input  logic [WORD_W-1:0] ptr_word,
   output logic              hit,
   output logic [WORD_W-1:0] bumped
);
   localparam logic [WORD_W-1:0] LO = WORD_W'(AUTO_BASE);
   localparam logic [WORD_W-1:0] HI = WORD_W'(AUTO_BASE + AUTO_COUNT - 1);

   generate
      if (AUTO_EN) begin : g_auto
         assign hit    = (ptr_addr >= LO) && (ptr_addr <= HI);
         assign bumped = ptr_word + WORD_W'(1);
      end else begin : g_plain
         logic unused_addr;
         assign unused_addr = ^ptr_addr;
         assign hit         = 1'b0;
         assign bumped      = ptr_word;
      end
   endgenerate
endmodule

// File: rtl/pea_seq.sv
module pea_seq
   import pea_pkg::*;
#(
   parameter int WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              indirect,
   input  logic [WORD_W-1:0] page_addr,
   input  logic              auto_hit,
   input  logic [WORD_W-1:0] bumped,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic [WORD_W-1:0] ptr_addr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [WORD_W-1:0] mem_wdata,
   output logic [WORD_W-1:0] ea,
   output logic              done,
   output pea_state_t        state
);
   pea_state_t        st_q;
   logic [WORD_W-1:0] ptr_q;
   logic [WORD_W-1:0] wbuf_q;
   logic [WORD_W-1:0] ea_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= PEA_IDLE;
         ptr_q  <= '0;
         wbuf_q <= '0;
         ea_q   <= '0;
      end else begin
         case (st_q)
            PEA_IDLE: begin
               if (start) begin
                  ptr_q <= page_addr;
                  if (indirect) begin
                     st_q <= PEA_READ;
                  end else begin
                     ea_q <= page_addr;
                     st_q <= PEA_DONE;
                  end
               end
            end
            PEA_READ: begin
               if (mem_ready) begin
                  if (auto_hit) begin
                     wbuf_q <= bumped;
                     st_q   <= PEA_WRITE;
                  end else begin
                     ea_q <= mem_rdata;
                     st_q <= PEA_DONE;
                  end
               end
            end
            PEA_WRITE: begin
               if (mem_ready) begin
                  ea_q <= wbuf_q;
                  st_q <= PEA_DONE;
               end
            end
            default: st_q <= PEA_IDLE;
         endcase
      end
   end

   assign ptr_addr  = ptr_q;
   assign mem_req   = (st_q == PEA_READ) || (st_q == PEA_WRITE);
   assign mem_we    = (st_q == PEA_WRITE);
   assign mem_wdata = wbuf_q;
   assign ea        = ea_q;
   assign done      = (st_q == PEA_DONE);
   assign state     = st_q;
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen
   import pea_pkg::*;
#(
   parameter int WORD_W     = 12,
   parameter int OFFS_W     = 7,
   parameter int IND_BIT    = 8,
   parameter int PAGE_BIT   = 7,
   parameter bit AUTO_EN    = 1'b1,
   parameter int AUTO_BASE  = 8,
   parameter int AUTO_COUNT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [11:0]       instr,
   input  logic [11:0]       fetch_addr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [11:0]       mem_addr,
   output logic [11:0]       mem_wdata,
   input  logic [11:0]       mem_rdata,
   input  logic              mem_ready,
   output logic [11:0]       ea,
   output logic              done
);
   generate
      if (WORD_W != 12) begin : g_bad_word
         $error("paged_ea_gen: port widths are fixed at 12 bits");
      end
      if (OFFS_W < 1 || OFFS_W >= WORD_W) begin : g_bad_offs
         $error("paged_ea_gen: offset width must be below word width");
      end
      if (IND_BIT < OFFS_W || PAGE_BIT < OFFS_W || IND_BIT == PAGE_BIT
          || IND_BIT >= WORD_W || PAGE_BIT >= WORD_W) begin : g_bad_flags
         $error("paged_ea_gen: flag bits must sit above the offset");
      end
      if (AUTO_COUNT < 1 || AUTO_BASE + AUTO_COUNT > (1 << OFFS_W)) begin : g_bad_auto
         $error("paged_ea_gen: auto-increment cells must lie in page zero");
      end
   endgenerate

   logic              indirect;
   logic [WORD_W-1:0] page_addr;
   logic [WORD_W-1:0] ptr_addr;
   logic              auto_hit;
   logic [WORD_W-1:0] bumped;
   pea_state_t        state;

   pea_decode #(
      .WORD_W  (WORD_W),
      .OFFS_W  (OFFS_W),
      .IND_BIT (IND_BIT),
      .PAGE_BIT(PAGE_BIT)
   ) u_dec (
      .instr     (instr),
      .fetch_addr(fetch_addr),
      .indirect  (indirect),
      .page_addr (page_addr)
   );

   pea_autoinc #(
      .WORD_W    (WORD_W),
      .AUTO_EN   (AUTO_EN),
      .AUTO_BASE (AUTO_BASE),
      .AUTO_COUNT(AUTO_COUNT)
   ) u_inc (
      .ptr_addr(ptr_addr),
      .ptr_word(mem_rdata),
      .hit     (auto_hit),
      .bumped  (bumped)
   );

   pea_seq #(
      .WORD_W(WORD_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .indirect (indirect),
      .page_addr(page_addr),
      .auto_hit (auto_hit),
      .bumped   (bumped),
      .mem_rdata(mem_rdata),
      .mem_ready(mem_ready),
      .ptr_addr (ptr_addr),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .mem_wdata(mem_wdata),
      .ea       (ea),
      .done     (done),
      .state    (state)
   );

   assign mem_addr = ptr_addr;
endmodule

// File: rtl/pea_checker.sv
module pea_checker
   import pea_pkg::*;
#(
   parameter int WORD_W     = 12,
   parameter int IND_BIT    = 8,
   parameter int AUTO_BASE  = 8,
   parameter int AUTO_COUNT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [WORD_W-1:0] instr,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ready,
   input logic [WORD_W-1:0] mem_addr,
   input logic [WORD_W-1:0] ea,
   input logic              done,
   input pea_state_t        state
);
   localparam logic [WORD_W-1:0] LO = WORD_W'(AUTO_BASE);
   localparam logic [WORD_W-1:0] HI = WORD_W'(AUTO_BASE + AUTO_COUNT - 1);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                     // R10
   AST_EA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(ea));                                              // R10
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9
   AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr >= LO && mem_addr <= HI));                      // R6
   AST_DIRECT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PEA_IDLE && start && !instr[IND_BIT]) |=> (done && !mem_req)); // R4
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PEA_READ && !mem_ready) |=> (state == PEA_READ));          // R11
endmodule

bind paged_ea_gen pea_checker #(
   .WORD_W    (WORD_W),
   .IND_BIT   (IND_BIT),
   .AUTO_BASE (AUTO_BASE),
   .AUTO_COUNT(AUTO_COUNT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .instr    (instr),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_ready(mem_ready),
   .mem_addr (mem_addr),
   .ea       (ea),
   .done     (done),
   .state    (state)
);

// File: tb/paged_ea_gen_test.sv
`timescale 1ns/1ps
module paged_ea_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [11:0] instr = '0;
   logic [11:0] fetch_addr = '0;
   logic        mem_req, mem_we, done;
   logic [11:0] mem_addr, mem_wdata, ea;
   logic [11:0] mem_rdata = '0;
   logic        mem_ready = 1'b0;

   int total = 0;
   int fails = 0;
   int lat = 0;
   int wcnt = 0;
   int wr_count = 0;
   int rd_count = 0;
   logic [11:0] cells [0:7];

   always #5 clk = ~clk;

   paged_ea_gen uut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .fetch_addr(fetch_addr), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ready(mem_ready), .ea(ea), .done(done)
   );

   function automatic logic [11:0] pattern(input logic [11:0] a);
      logic [23:0] t;
      t = a * 24'd1237 + 24'd291;
      return t[11:0];
   endfunction

   function automatic bit is_cell(input logic [11:0] a);
      return (a >= 12'o10) && (a <= 12'o17);
   endfunction

   function automatic logic [11:0] peek(input logic [11:0] a);
      if (is_cell(a)) return cells[a[2:0]];
      return pattern(a);
   endfunction

   // memory model: answers after lat wait cycles
   always @(negedge clk) begin
      if (mem_req) begin
         if (wcnt >= lat) begin
            mem_ready = 1'b1;
            wcnt = 0;
            if (mem_we) begin
               wr_count++;
               if (is_cell(mem_addr)) cells[mem_addr[2:0]] = mem_wdata;
            end else begin
               rd_count++;
               mem_rdata = peek(mem_addr);
            end
         end else begin
            mem_ready = 1'b0;
            wcnt++;
         end
      end else begin
         mem_ready = 1'b0;
         wcnt = 0;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%o expected=%o", req, act, exp);
      end
   endtask

   task automatic run(input logic [11:0] ins, input logic [11:0] fa, input int l, input string tag);
      logic [11:0] pa, exp_ea, old, ea_before;
      int exp_cyc, n, wr0, rd0, exp_wr, exp_rd;
      bit auto;
      pa = ins[7] ? {fa[11:7], ins[6:0]} : {5'b0, ins[6:0]};
      auto = ins[8] && is_cell(pa);
      old = peek(pa);
      if (!ins[8]) begin exp_ea = pa; exp_cyc = 1; exp_wr = 0; exp_rd = 0; end
      else if (auto) begin exp_ea = old + 12'd1; exp_cyc = 1 + 2*(l+1); exp_wr = 1; exp_rd = 1; end
      else begin exp_ea = old; exp_cyc = 1 + (l+1); exp_wr = 0; exp_rd = 1; end
      lat = l;
      wr0 = wr_count; rd0 = rd_count;
      @(negedge clk);
      start = 1'b1; instr = ins; fetch_addr = fa;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      while (!done && n < 60) begin
         @(negedge clk);
         n++;
      end
      chk(ea == exp_ea, {tag, " ea"}, ea, exp_ea);
      chk(n == exp_cyc, "R9 completion cycles", 12'(n), 12'(exp_cyc));
      chk(wr_count - wr0 == exp_wr, "R5/R6/R8 write count", 12'(wr_count - wr0), 12'(exp_wr));
      chk(rd_count - rd0 == exp_rd, "R4/R5 read count", 12'(rd_count - rd0), 12'(exp_rd));
      if (auto) chk(cells[pa[2:0]] == exp_ea, "R6 write-back value", cells[pa[2:0]], exp_ea);
      if (!ins[8] && is_cell(pa)) chk(cells[pa[2:0]] == old, "R8 cell untouched", cells[pa[2:0]], old);
      ea_before = ea;
      @(negedge clk);
      chk(done == 1'b0, "R10 done single cycle", 12'(done), 12'd0);
      @(negedge clk);
      chk(ea == ea_before, "R10 ea held", ea, ea_before);
   endtask

   initial begin
      #(150000 * 10);
      fails++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic [11:0] e1;
      for (int i = 0; i < 8; i++) cells[i] = pattern(12'(i + 8));
      cells[7] = 12'o7777;
      repeat (3) @(negedge clk);
      chk(done == 0, "R12 done reset", 12'(done), 0);
      chk(mem_req == 0 && mem_we == 0, "R12 req reset", 12'({mem_req, mem_we}), 0);
      chk(ea == 0, "R12 ea reset", ea, 0);
      rst_n = 1'b1;

      // R1 R2 R3: direct sweep, all offsets, both page modes, varied opcode
      for (int p = 0; p < 2; p++)
         for (int o = 0; o < 128; o++)
            run({3'(o % 7), 1'b0, 1'(p), 7'(o)}, 12'(o * 293 + 12'o1234), 0,
                p ? "R3 current page" : "R2 page zero");

      // R5 R9: indirect sweep on the current page, latencies 0..2
      for (int l = 0; l < 3; l++)
         for (int o = 0; o < 128; o += 5)
            run({3'(l), 1'b1, 1'b1, 7'(o)}, 12'(12'o4400 + o * 9), l, "R5 indirect page");

      // R6 R7: all auto cells, twice each, several latencies (cell 17 starts at 7777)
      for (int r = 0; r < 2; r++)
         for (int c = 8; c < 16; c++)
            run({3'o2, 1'b1, 1'b0, 7'(c)}, 12'o6543, r * 2, c == 15 && r == 0 ? "R7 wrap" : "R6 auto");
      chk(cells[7] == 12'd1, "R7 wrap after two bumps", cells[7], 12'd1);

      // R8: direct references to the auto cells
      for (int c = 8; c < 16; c++) run({3'o5, 1'b0, 1'b0, 7'(c)}, 12'o0200, 1, "R8 direct cell");

      // R1: the indirect flag and page flag from the same offset in page zero, opcode ignored
      run({3'o7, 1'b1, 1'b0, 7'o20}, 12'o7600, 1, "R1 indirect page zero");

      // R11: a second start during a slow indirect reference is dropped
      lat = 6;
      e1 = pattern(12'o3021);
      @(negedge clk);
      start = 1'b1; instr = {3'o1, 1'b1, 1'b1, 7'o21}; fetch_addr = 12'o3000;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      start = 1'b1; instr = {3'o1, 1'b0, 1'b0, 7'o55};
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 30 && !done; k++) @(negedge clk);
      chk(ea == e1, "R11 busy start ignored", ea, e1);
      @(negedge clk);
      @(negedge clk);
      chk(ea == e1 && !done, "R11 no second completion", ea, e1);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule